// File: doc/BRIEF.md
# SPI Register Access Slave

This block terminates fixed-length, full-duplex SPI frames from a host processor and maps them onto a bank of 32 registers of 25 bits each. Every frame is one 32-bit word sent most significant bit first. The top bit selects the operation, the next five bits name the register, and the low 25 bits carry the payload. A write frame stores the payload into the addressed register. A read frame shifts the addressed register's contents back to the host during the same frame. That works because the address is complete before the payload bits are due on the output line.

The SPI pins are resynchronised into the system clock domain, and shifting follows mode 0. The host drives data on the falling edge of the serial clock and samples on the rising edge, with the clock idling low. A configuration input selects whether chip select is active low (the default use) or active high.

On the internal side, a one-cycle write strobe carries the address and data of every accepted write. Neighbouring interrupt or converter logic can use it to track the registers it owns. A combinational local read port exposes any register to that logic. A parameter mask marks which addresses exist; holes read as zero and ignore writes.

Top module: `spi_regacc`

## Requirements
- R1: A frame is 32 serial clocks in mode 0, MSB first. Bit 31 = 1 selects a write and bit 31 = 0 selects a read; a read frame changes no register whatever its other bits hold.
- R2: Bits 30:26 of the frame form the register address, and each of the 32 addresses selects its own register.
- R3: A write stores frame bits 24:0 into the addressed register. Frame bit 25 is ignored on a write.
- R4: On a read, the host receives the addressed register's value in bits 24:0 of the same frame, with bits 31:25 returned as 0. The serial output is 0 while the block is not selected.
- R5: A write takes effect only after all 32 bits have arrived and chip select has deasserted. It then raises `wr_stb` for exactly one clock, with `wr_addr` and `wr_data` carrying the register number and the stored 25 bits.
- R6: A frame ended by chip-select deassertion before 32 clocks is discarded: no strobe and no register change.
- R7: A frame that receives more than 32 clocks is discarded: no strobe and no register change.
- R8: Addresses whose bit in `IMPL_MASK` is 0 read as zero, ignore writes, and produce no strobe. The default mask leaves addresses 30 and 31 unimplemented.
- R9: With `cs_act_high` = 0, chip select is active low; with `cs_act_high` = 1, it is active high. Serial clocks outside the active level have no effect.
- R10: After reset, every register holds 0 and `wr_stb` and `spi_miso` are 0.
- R11: `loc_data` shows the register selected by `loc_addr`, and it reflects a write from the clock cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs | input | 1 | Chip select from the host, polarity set by `cs_act_high` |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| cs_act_high | input | 1 | 1 makes chip select active high, 0 active low |
| wr_stb | output | 1 | One-cycle pulse for each accepted write |
| wr_addr | output | 5 | Register number of the accepted write |
| wr_data | output | 25 | Value stored by the accepted write |
| loc_addr | input | 5 | Local read port address |
| loc_data | output | 25 | Local read port data |

## Verification
The bench sweeps every address twice, each time writing a per-address value and then reading all of them back. The second pass uses complemented values, so stuck bits and crossed address decodes both show up, and holes must still read zero. The write frames set bit 25, and the reads check the top seven returned bits, which tells a stored or echoed bit 25 apart from a correct one. Frames cut short, frames with 33 clocks, and writes held open after the 32nd clock separate the commit rules from plain shifting. A reset with the opposite chip-select polarity then repeats a write and read, and also clocks a frame at the inactive level, which must leave the register untouched.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;

    localparam int FRAME_W  = 32;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 25;
    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int CNT_W    = $clog2(FRAME_W + 1);
    // serial clocks after which op and address are complete
    localparam int HDR_BITS = 1 + ADDR_W;

    // frame layout, MSB first on the wire
    typedef struct packed {
        logic              op;     // 1 = write, 0 = read
        logic [ADDR_W-1:0] addr;
        logic              pad;    // ignored on write, 0 on read
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic cs_level_active(input logic pin, input logic act_high);
        return act_high ? pin : ~pin;
    endfunction

endpackage

// File: rtl/spi_regacc_front.sv
module spi_regacc_front
    import spi_regacc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_pin,
    input  logic cs_pin,
    input  logic mosi_pin,
    input  logic cs_high,
    output logic cs_act,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sclk_sy;
    logic [TOP:0] cs_sy;
    logic [TOP:0] mosi_sy;
    logic         sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sy <= '0;
            mosi_sy <= '0;
            cs_sy   <= {SYNC_STAGES{~cs_high}};
            sclk_d  <= 1'b0;
        end else begin
            sclk_sy <= {sclk_sy[TOP-1:0], sclk_pin};
            cs_sy   <= {cs_sy[TOP-1:0], cs_pin};
            mosi_sy <= {mosi_sy[TOP-1:0], mosi_pin};
            sclk_d  <= sclk_sy[TOP];
        end
    end

    assign cs_act    = cs_level_active(cs_sy[TOP], cs_high);
    assign sclk_rise = sclk_sy[TOP] & ~sclk_d;
    assign sclk_fall = ~sclk_sy[TOP] & sclk_d;
    assign mosi_s    = mosi_sy[TOP];

endmodule

// File: rtl/spi_regacc_engine.sv
module spi_regacc_engine
    import spi_regacc_pkg::*;
#(
    parameter logic [NUM_REGS-1:0] IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              miso,
    output logic              wr_stb,
    output wr_req_t           wr_req
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS);

    logic [FRAME_W-1:0] rx_sh;
    logic [DATA_W-1:0]  tx_sh;
    logic [CNT_W-1:0]   bit_cnt;
    logic               overrun;
    logic               miso_q;
    logic               act_d;
    frame_t             rx_f;

    assign rx_f    = rx_sh;
    assign rd_addr = rx_sh[ADDR_W-1:0];   // valid once the header is in

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh   <= '0;
            tx_sh   <= '0;
            bit_cnt <= '0;
            overrun <= 1'b0;
            miso_q  <= 1'b0;
            act_d   <= 1'b0;
            wr_stb  <= 1'b0;
            wr_req  <= '0;
        end else begin
            act_d  <= cs_act;
            wr_stb <= 1'b0;
            if (!cs_act) begin
                if (act_d && bit_cnt == CNT_FULL && !overrun &&
                    rx_f.op && IMPL_MASK[rx_f.addr]) begin
                    wr_stb      <= 1'b1;
                    wr_req.addr <= rx_f.addr;
                    wr_req.data <= rx_f.data;
                end
                bit_cnt <= '0;
                overrun <= 1'b0;
                miso_q  <= 1'b0;
                tx_sh   <= '0;
            end else begin
                if (sclk_rise) begin
                    rx_sh <= {rx_sh[FRAME_W-2:0], mosi_s};
                    if (bit_cnt == CNT_FULL) begin
                        overrun <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (sclk_fall) begin
                    if (bit_cnt == CNT_HDR) begin
                        tx_sh  <= rd_data;    // pad bit goes out now
                        miso_q <= 1'b0;
                    end else if (bit_cnt > CNT_HDR) begin
                        miso_q <= tx_sh[DATA_W-1];
                        tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
                    end else begin
                        miso_q <= 1'b0;
                    end
                end
            end
        end
    end

    assign miso = cs_act & miso_q;

endmodule

// File: rtl/spi_regacc_bank.sv
module spi_regacc_bank
    import spi_regacc_pkg::*;
#(
    parameter logic [NUM_REGS-1:0] IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  wr_req_t           wr_req,
    input  logic [ADDR_W-1:0] spi_addr,
    output logic [DATA_W-1:0] spi_data,
    input  logic [ADDR_W-1:0] loc_addr,
    output logic [DATA_W-1:0] loc_data
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (IMPL_MASK[i]) begin : g_impl
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_stb && wr_req.addr == ADDR_W'(i)) begin
                    q <= wr_req.data;
                end
            end
            assign regs[i] = q;
        end else begin : g_hole
            assign regs[i] = '0;
        end
    end

    assign spi_data = regs[spi_addr];
    assign loc_data = regs[loc_addr];

endmodule

// File: rtl/spi_regacc.sv
module spi_regacc
    import spi_regacc_pkg::*;
#(
    parameter logic [NUM_REGS-1:0] IMPL_MASK   = 32'h3FFF_FFFF,
    parameter int                  SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              cs_act_high,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] loc_addr,
    output logic [DATA_W-1:0] loc_data
);
    logic              cs_act;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              mosi_s;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    wr_req_t           wr_req;

    spi_regacc_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk       (clk),
        .rst       (rst),
        .sclk_pin  (spi_sclk),
        .cs_pin    (spi_cs),
        .mosi_pin  (spi_mosi),
        .cs_high   (cs_act_high),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s)
    );

    spi_regacc_engine #(.IMPL_MASK(IMPL_MASK)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .miso      (spi_miso),
        .wr_stb    (wr_stb),
        .wr_req    (wr_req)
    );

    spi_regacc_bank #(.IMPL_MASK(IMPL_MASK)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .wr_req   (wr_req),
        .spi_addr (rd_addr),
        .spi_data (rd_data),
        .loc_addr (loc_addr),
        .loc_data (loc_data)
    );

    assign wr_addr = wr_req.addr;
    assign wr_data = wr_req.data;

endmodule

// File: rtl/spi_regacc_chk.sv
module spi_regacc_chk
    import spi_regacc_pkg::*;
#(
    parameter logic [NUM_REGS-1:0] IMPL_MASK = '1
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_act,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] loc_addr,
    input logic [DATA_W-1:0] loc_data
);
    // R5: a strobe lasts one cycle
    p_stb_single_r5: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R5: a strobe only follows a deselected cycle
    p_stb_after_deselect_r5: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> !$past(cs_act));

    // R8: holes never strobe
    p_no_hole_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> IMPL_MASK[wr_addr]);

    // R11: local port follows a write one cycle later
    p_loc_follows_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && loc_addr == wr_addr) |=>
        (loc_addr != $past(loc_addr)) || (loc_data == $past(wr_data)));

    // R6: without a strobe no register changes
    p_quiet_without_stb_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> (loc_addr != $past(loc_addr)) || $stable(loc_data));

endmodule

bind spi_regacc spi_regacc_chk #(.IMPL_MASK(IMPL_MASK)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_act   (cs_act),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .loc_addr (loc_addr),
    .loc_data (loc_data)
);

// File: tb/test_spi_regacc.sv
`timescale 1ns/1ps
module test_spi_regacc;
    localparam logic [31:0] IMPL = 32'h3FFF_FFFF;
    localparam int HP = 6;           // serial half period in clk cycles
    localparam int WATCHDOG = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        cs = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic        cs_hi = 1'b0;
    logic        wr_stb;
    logic [4:0]  wr_addr;
    logic [24:0] wr_data;
    logic [4:0]  loc_addr = '0;
    logic [24:0] loc_data;

    int total = 0;
    int bad = 0;
    int stb_cnt = 0;
    logic [4:0]  last_addr = '0;
    logic [24:0] last_data = '0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spi_regacc #(.IMPL_MASK(IMPL)) i_spi_regacc (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs(cs), .spi_mosi(mosi),
        .spi_miso(miso), .cs_act_high(cs_hi), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .loc_addr(loc_addr),
        .loc_data(loc_data)
    );

    always @(posedge clk) begin
        if (wr_stb) begin
            stb_cnt   <= stb_cnt + 1;
            last_addr <= wr_addr;
            last_data <= wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [24:0] pat(input int a, input int p);
        logic [31:0] v;
        v = 32'(a) * 32'h0013_579B + 32'h0000_0A5C;
        if (p != 0) v = ~v;
        return v[24:0];
    endfunction

    function automatic bit impl(input int a);
        return IMPL[a];
    endfunction

    // clock nbits with the bus selected; level is the active cs level
    task automatic shift(input logic [31:0] tx, input int nbits, input logic level,
                         output logic [31:0] rx);
        rx = '0;
        cs = level;
        idle(4);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 32) ? tx[31 - i] : 1'b0;
            idle(HP);
            rx = {rx[30:0], miso};
            sclk = 1'b1;
            idle(HP);
            sclk = 1'b0;
        end
        idle(HP);
    endtask

    task automatic release_cs(input logic level);
        cs = ~level;
        mosi = 1'b0;
        idle(8);
    endtask

    task automatic frame(input logic [31:0] tx, input int nbits, output logic [31:0] rx);
        shift(tx, nbits, cs_hi, rx);
        release_cs(cs_hi);
    endtask

    function automatic logic [31:0] wr_frame(input int a, input logic [24:0] d);
        return {1'b1, 5'(a), 1'b1, d};   // bit 25 set on purpose
    endfunction

    function automatic logic [31:0] rd_frame(input int a);
        return {1'b0, 5'(a), 1'b1, 25'h155_5555};
    endfunction

    task automatic spi_read(input int a, output logic [31:0] rx);
        frame(rd_frame(a), 32, rx);
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=done", WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rx;
        int s0;
        idle(4);
        rst = 1'b0;
        idle(4);

        // R10: reset state
        chk(miso == 1'b0, "R10 miso", 32'(miso), 0);
        chk(wr_stb == 1'b0, "R10 strobe", 32'(wr_stb), 0);
        for (int a = 0; a < 32; a++) begin
            loc_addr = 5'(a);
            idle(1);
            chk(loc_data == '0, "R10 reg", 32'(loc_data), 0);
        end
        spi_read(3, rx);
        chk(rx == '0, "R10 spi read", rx, 0);

        // R1 R2 R3 R4 R5 R8 R11: two full sweeps
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < 32; a++) begin
                s0 = stb_cnt;
                frame(wr_frame(a, pat(a, p)), 32, rx);
                if (impl(a)) begin
                    chk(stb_cnt == s0 + 1, "R5 strobe count", 32'(stb_cnt - s0), 1);
                    chk(last_addr == 5'(a), "R5 strobe addr", 32'(last_addr), 32'(a));
                    chk(last_data == pat(a, p), "R5 strobe data", 32'(last_data),
                        32'(pat(a, p)));
                end else begin
                    chk(stb_cnt == s0, "R8 hole strobe", 32'(stb_cnt - s0), 0);
                end
            end
            for (int a = 0; a < 32; a++) begin
                logic [24:0] e;
                e = impl(a) ? pat(a, p) : '0;
                spi_read(a, rx);
                chk(rx[24:0] == e, impl(a) ? "R2 R3 R4 readback" : "R8 hole reads zero",
                    32'(rx[24:0]), 32'(e));
                chk(rx[31:25] == '0, "R3 R4 upper bits zero", 32'(rx[31:25]), 0);
                loc_addr = 5'(a);
                idle(1);
                chk(loc_data == e, "R11 local port", 32'(loc_data), 32'(e));
            end
        end

        // R1: a read frame leaves the register alone
        spi_read(9, rx);
        spi_read(9, rx);
        chk(rx[24:0] == pat(9, 1), "R1 read no side effect", 32'(rx[24:0]),
            32'(pat(9, 1)));

        // R5: no strobe until chip select goes away
        s0 = stb_cnt;
        shift(wr_frame(4, 25'h0ABCDE), 32, cs_hi, rx);
        idle(20);
        chk(stb_cnt == s0, "R5 held select no strobe", 32'(stb_cnt - s0), 0);
        loc_addr = 5'd4;
        idle(1);
        chk(loc_data == pat(4, 1), "R5 held select no write", 32'(loc_data),
            32'(pat(4, 1)));
        release_cs(cs_hi);
        chk(stb_cnt == s0 + 1, "R5 strobe after release", 32'(stb_cnt - s0), 1);
        chk(loc_data == 25'h0ABCDE, "R5 write after release", 32'(loc_data),
            32'h0ABCDE);

        // R6: aborted frame
        s0 = stb_cnt;
        frame(wr_frame(7, 25'h1234567 & 25'h1FF_FFFF), 20, rx);
        chk(stb_cnt == s0, "R6 abort no strobe", 32'(stb_cnt - s0), 0);
        spi_read(7, rx);
        chk(rx[24:0] == pat(7, 1), "R6 abort no write", 32'(rx[24:0]),
            32'(pat(7, 1)));

        // R7: over-length frame
        s0 = stb_cnt;
        frame(wr_frame(8, 25'h0F0F0F), 33, rx);
        chk(stb_cnt == s0, "R7 overlength no strobe", 32'(stb_cnt - s0), 0);
        spi_read(8, rx);
        chk(rx[24:0] == pat(8, 1), "R7 overlength no write", 32'(rx[24:0]),
            32'(pat(8, 1)));

        // R9: active-high chip select after a fresh reset
        cs_hi = 1'b1;
        cs = 1'b0;
        rst = 1'b1;
        idle(4);
        rst = 1'b0;
        idle(4);
        frame(wr_frame(12, 25'h1C3A5F0), 32, rx);
        spi_read(12, rx);
        chk(rx[24:0] == 25'h1C3A5F0, "R9 active high write/read", 32'(rx[24:0]),
            32'h1C3A5F0);
        s0 = stb_cnt;
        shift(wr_frame(12, 25'h0000011), 32, 1'b0, rx);   // inactive level
        release_cs(1'b0);
        chk(stb_cnt == s0, "R9 inactive level no strobe", 32'(stb_cnt - s0), 0);
        spi_read(12, rx);
        chk(rx[24:0] == 25'h1C3A5F0, "R9 inactive level no write", 32'(rx[24:0]),
            32'h1C3A5F0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule